// File: doc/BRIEF.md
# Two-Delay Pipelined LMS Adaptive Filter

This block is an adaptive FIR filter of `TAPS` coefficients that adjusts its own weights by the least-mean-square rule while it filters. It takes one input sample `x_in` and one desired-response sample `d_in` on every clock. It returns the full-precision filter output and the error between the desired response and that output. A typical use is system identification or echo cancellation, where the error drives the weights toward the unknown response.

The datapath is cut into three register stages. The first stage forms all weight-by-sample products, adds them in adjacent pairs, and stores the `TAPS/2` pair sums. The second stage adds the pair sums to form the output. It subtracts that output from the desired sample, which is held back one clock so that both refer to the same sample. The output and the error are then registered. The third stage adds a scaled error-times-sample increment to every weight. Both the error and the samples used there date from two samples before the current one, so the filter has exactly two adaptation delays. The step size is a power of two and is applied as an arithmetic right shift. The block has no control states: every register advances on every clock, and a two-flop tag carries `in_valid` alongside the data.

Samples, weights and errors are 12-bit two's complement values with 11 fraction bits. The output keeps full precision: 24 product bits plus log2(`TAPS`) growth bits.

Top module: `lms2d_filter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `y_out`, `e_out` and `out_valid` are 0. Reset also clears every weight, every stored sample, every pair sum and the held desired sample, so the first outputs after reset follow from zero weights.
- R2: For the sample pair presented in clock n, `y_out` during clock n+2 equals the sum over k of w_n(k)·x(n−k), where x(n−k) is the input k clocks earlier and is zero before reset release. The sum is kept exact in 2·12+log2(`TAPS`) bits.
- R3: During the same clock as R2, `e_out` equals the low 12 bits of d(n) − (y_n >>> 11), with an arithmetic shift.
- R4: `out_valid` in clock n+2 equals `in_valid` in clock n. Samples are consumed on every clock whatever `in_valid` is, so a low `in_valid` changes only the tag.
- R5: At the end of clock n every weight becomes w(k) + low 12 bits of (((e(n−2) >>> `MU_SHIFT`) · x(n−2−k)) >>> 11). The result wraps modulo 2^12. Here e(n−2) is the value on `e_out` during clock n.
- R6: The error of sample n first changes the weights used by sample n+3. Samples n+1 and n+2 are filtered with weights that do not include it.
- R7: At full-scale inputs, both the weight update and the error wrap in two's complement exactly as R3 and R5 state, with no saturation.
- R8: Asserting `rst` in the middle of a stream returns the block to the R1 state, and filtering restarts from zero weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tag marking the present sample pair as meaningful |
| x_in | input | 12 | Input sample, signed, 11 fraction bits |
| d_in | input | 12 | Desired-response sample, signed, 11 fraction bits |
| out_valid | output | 1 | Tag of the sample pair whose results are on `y_out`/`e_out` |
| y_out | output | 2·12+log2(TAPS) | Full-precision filter output, signed |
| e_out | output | 12 | Error, signed, 11 fraction bits |

## Verification
A wrong weight is not visible at the ports until it is used. A weight updated in clock n first shows on `y_out` two clocks later, and on `e_out` in the same clock. A stale or early error feeding the update shows up as a change in adaptation timing. The clearest case is an error impulse, which must leave the outputs of the next two samples untouched and alter the third. A misaligned desired sample or a wrong fraction shift corrupts `e_out` in the very first cycle that carries a nonzero output. A slip in the tag pipeline shows as an `out_valid` pattern shifted by one clock against the stimulus.

// File: rtl/lms_pkg.sv
package lms_pkg;
    // Sample, weight and error word width; one sign bit, rest fraction.
    localparam int DW   = 12;
    localparam int FRAC = DW - 1;
    localparam int PW2  = 2 * DW;       // exact product width
    localparam int PSW  = 2 * DW + 1;   // pair-sum width

    typedef logic signed [DW-1:0] sample_t;
endpackage

// File: rtl/lms_tap_line.sv
// Input history: taps[0] is the live input, taps[j] the sample j clocks old.
// Extends two positions past the filter taps for the delayed update.
module lms_tap_line
    import lms_pkg::*;
#(
    parameter int TAPS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t x_in,
    output sample_t taps [TAPS+2]
);
    localparam int DEPTH = TAPS + 1;

    sample_t hist [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) hist[j] <= '0;
        end else begin
            hist[0] <= x_in;
            for (int j = 1; j < DEPTH; j++) hist[j] <= hist[j-1];
        end
    end

    always_comb begin
        taps[0] = x_in;
        for (int j = 1; j < TAPS + 2; j++) taps[j] = hist[j-1];
    end
endmodule

// File: rtl/lms_stage1.sv
// Products and the first adder level, registered; desired sample held one clock.
module lms_stage1
    import lms_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int HALF = TAPS / 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sample_t               taps [TAPS+2],
    input  sample_t               w    [TAPS],
    input  sample_t               d_in,
    output logic signed [PSW-1:0] ps   [HALF],
    output sample_t               d_q
);
    logic signed [PW2-1:0] prod [TAPS];
    logic signed [PSW-1:0] pair [HALF];

    always_comb begin
        for (int k = 0; k < TAPS; k++)
            prod[k] = PW2'(w[k]) * PW2'(taps[k]);
        for (int i = 0; i < HALF; i++)
            pair[i] = PSW'(prod[2*i]) + PSW'(prod[2*i+1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF; i++) ps[i] <= '0;
            d_q <= '0;
        end else begin
            for (int i = 0; i < HALF; i++) ps[i] <= pair[i];
            d_q <= d_in;
        end
    end
endmodule

// File: rtl/lms_stage2.sv
// Remaining adder levels plus the error subtraction, registered at the outputs.
module lms_stage2
    import lms_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int HALF = TAPS / 2,
    localparam int YW   = 2 * DW + $clog2(TAPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [PSW-1:0] ps [HALF],
    input  sample_t               d_q,
    output logic signed [YW-1:0]  y_q,
    output sample_t               e_q
);
    logic signed [YW-1:0] acc;
    logic signed [YW-1:0] scaled;
    logic signed [YW-1:0] diff;

    always_comb begin
        acc = '0;
        for (int i = 0; i < HALF; i++) acc = acc + YW'(ps[i]);
        scaled = acc >>> FRAC;
        diff   = YW'(d_q) - scaled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
            e_q <= '0;
        end else begin
            y_q <= acc;
            e_q <= diff[DW-1:0];
        end
    end
endmodule

// File: rtl/lms_weight_bank.sv
// Weight registers; each adds (e >>> MU) * x(two back) scaled to the fraction.
module lms_weight_bank
    import lms_pkg::*;
#(
    parameter int TAPS     = 8,
    parameter int MU_SHIFT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t e_q,
    input  sample_t taps [TAPS+2],
    output sample_t w    [TAPS]
);
    sample_t               mu_e;
    logic signed [PW2-1:0] step [TAPS];

    always_comb begin
        mu_e = e_q >>> MU_SHIFT;
        for (int k = 0; k < TAPS; k++)
            step[k] = (PW2'(mu_e) * PW2'(taps[k+2])) >>> FRAC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) w[k] <= '0;
        end else begin
            for (int k = 0; k < TAPS; k++) w[k] <= w[k] + step[k][DW-1:0];
        end
    end
endmodule

// File: rtl/lms2d_filter.sv
// Top: three-stage LMS filter with two adaptation delays.
module lms2d_filter
    import lms_pkg::*;
#(
    parameter int TAPS     = 8,
    parameter int MU_SHIFT = 4,
    localparam int HALF = TAPS / 2,
    localparam int YW   = 2 * DW + $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] d_in,
    output logic                 out_valid,
    output logic signed [YW-1:0] y_out,
    output logic signed [DW-1:0] e_out
);
    sample_t               taps [TAPS+2];
    sample_t               w_cur [TAPS];
    logic signed [PSW-1:0] ps [HALF];
    sample_t               d_q;
    sample_t               e_q;
    logic                  tag1;
    logic                  tag2;

    lms_tap_line #(.TAPS(TAPS)) u_line (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_in),
        .taps (taps)
    );

    lms_stage1 #(.TAPS(TAPS)) u_s1 (
        .clk  (clk),
        .rst  (rst),
        .taps (taps),
        .w    (w_cur),
        .d_in (d_in),
        .ps   (ps),
        .d_q  (d_q)
    );

    lms_stage2 #(.TAPS(TAPS)) u_s2 (
        .clk (clk),
        .rst (rst),
        .ps  (ps),
        .d_q (d_q),
        .y_q (y_out),
        .e_q (e_q)
    );

    lms_weight_bank #(.TAPS(TAPS), .MU_SHIFT(MU_SHIFT)) u_wb (
        .clk  (clk),
        .rst  (rst),
        .e_q  (e_q),
        .taps (taps),
        .w    (w_cur)
    );

    // Sample tag rides the two data stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag1 <= 1'b0;
            tag2 <= 1'b0;
        end else begin
            tag1 <= in_valid;
            tag2 <= tag1;
        end
    end

    assign out_valid = tag2;
    assign e_out     = e_q;
endmodule

// File: rtl/lms2d_chk.sv
module lms2d_chk
    import lms_pkg::*;
#(
    parameter int TAPS = 8,
    parameter int YW   = 2 * DW + 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input sample_t              d_in,
    input logic signed [YW-1:0] y_out,
    input sample_t              e_out,
    input logic                 out_valid,
    input sample_t              w_cur [TAPS]
);
    logic                 vh1, vh2;
    sample_t              dh1, dh2;
    logic signed [YW-1:0] ref_diff;
    sample_t              ref_e;
    logic [TAPS*DW-1:0]   w_pk;

    always_ff @(posedge clk) begin
        if (rst) begin
            vh1 <= 1'b0;
            vh2 <= 1'b0;
            dh1 <= '0;
            dh2 <= '0;
        end else begin
            vh1 <= in_valid;
            vh2 <= vh1;
            dh1 <= d_in;
            dh2 <= dh1;
        end
    end

    always_comb begin
        ref_diff = YW'(dh2) - (y_out >>> FRAC);
        ref_e    = ref_diff[DW-1:0];
        for (int k = 0; k < TAPS; k++) w_pk[k*DW +: DW] = w_cur[k];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (y_out == '0 && e_out == '0 && !out_valid)); // R1

    AST_ERR_FROM_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        e_out == ref_e); // R3

    AST_TAG_LAG: assert property (@(posedge clk) disable iff (rst)
        out_valid == vh2); // R4

    AST_HOLD_ON_ZERO_ERR: assert property (@(posedge clk) disable iff (rst)
        (e_out == '0) |=> $stable(w_pk)); // R5
endmodule

bind lms2d_filter lms2d_chk #(.TAPS(TAPS), .YW(YW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d_in      (d_in),
    .y_out     (y_out),
    .e_out     (e_out),
    .out_valid (out_valid),
    .w_cur     (w_cur)
);

// File: tb/sim_lms2d_filter.sv
`timescale 1ns/1ps
module sim_lms2d_filter;
    import lms_pkg::*;

    localparam int TAPS = 8;
    localparam int MU   = 4;
    localparam int YW   = 2 * DW + $clog2(TAPS);
    localparam int NV   = 16;

    localparam int XTAB [NV] = '{ 512, -300, 1200, 77, -1500, 900, 33, -640,
                                  1800, -2000, 450, 10, -900, 1500, -120, 700 };
    localparam int DTAB [NV] = '{ 200, -100, 800, 300, -900, 400, -50, -700,
                                  1000, -1200, 600, -30, -500, 900, 100, 350 };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic signed [DW-1:0] d_in = '0;
    logic                 out_valid;
    logic signed [YW-1:0] y_out;
    logic signed [DW-1:0] e_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural model of the delayed LMS recursion, built from R2..R5.
    longint mw [TAPS];
    longint mx [TAPS+2];
    longint ey [2];
    longint ee [2];
    bit     ev [2];
    longint me1, me2;

    always #2 clk = ~clk;

    lms2d_filter #(.TAPS(TAPS), .MU_SHIFT(MU)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .x_in      (x_in),
        .d_in      (d_in),
        .out_valid (out_valid),
        .y_out     (y_out),
        .e_out     (e_out)
    );

    function automatic longint wrap12(longint v);
        logic signed [DW-1:0] t;
        t = v[DW-1:0];
        return t;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < TAPS; k++) mw[k] = 0;
        for (int j = 0; j < TAPS + 2; j++) mx[j] = 0;
        for (int j = 0; j < 2; j++) begin
            ey[j] = 0; ee[j] = 0; ev[j] = 1'b0;
        end
        me1 = 0;
        me2 = 0;
    endtask

    // Called at a falling edge: check the results of two samples back, then
    // drive a new sample and advance the model by one clock.
    task automatic step(longint x, longint d, bit v, string tag);
        longint y, e;
        check($sformatf("R2 y_out %s", tag), longint'(y_out), ey[1]);
        check($sformatf("R3 e_out %s", tag), longint'(e_out), ee[1]);
        check($sformatf("R4 out_valid %s", tag), longint'(out_valid), longint'(ev[1]));
        x_in = DW'(x);
        d_in = DW'(d);
        in_valid = v;
        for (int j = TAPS + 1; j > 0; j--) mx[j] = mx[j-1];
        mx[0] = x;
        y = 0;
        for (int k = 0; k < TAPS; k++) y += mw[k] * mx[k];
        e = wrap12(d - (y >>> FRAC));
        for (int k = 0; k < TAPS; k++)
            mw[k] = wrap12(mw[k] + wrap12(((me2 >>> MU) * mx[k+2]) >>> FRAC));
        me2 = me1;
        me1 = e;
        ey[1] = ey[0]; ee[1] = ee[0]; ev[1] = ev[0];
        ey[0] = y;     ee[0] = e;     ev[0] = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        x_in = '0;
        d_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check($sformatf("R1 y_out in reset %s", tag), longint'(y_out), 0);
        check($sformatf("R1 e_out in reset %s", tag), longint'(e_out), 0);
        check($sformatf("R1 out_valid in reset %s", tag), longint'(out_valid), 0);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        apply_reset("power-up");

        // Vector table walked twice so the weights keep adapting.
        for (int pass = 0; pass < 2; pass++)
            for (int i = 0; i < NV; i++)
                step(XTAB[i], DTAB[i], 1'b1, "table");

        // R4: gaps in the tag; data still advance every clock.
        for (int i = 0; i < 10; i++)
            step(XTAB[i] / 2, DTAB[i], (i % 3) != 1, "tag gaps");

        // R8: reset in the middle of a stream.
        apply_reset("mid-stream");

        // R6: one error impulse; samples n+1 and n+2 stay unadapted.
        for (int i = 0; i < 6; i++) begin
            if (i == 3 || i == 4)
                check("R6 output before adaptation", longint'(y_out), 0);
            if (i == 5)
                check("R6 output after adaptation", longint'(y_out), 31744);
            step(1024, (i == 0) ? 1000 : 0, 1'b1, "impulse");
        end

        // R7: full-scale alternating stimulus to force two's complement wrap.
        for (int i = 0; i < 40; i++)
            step((i % 2) ? 2047 : -2048, (i % 2) ? -2048 : 2047, 1'b1, "R7 full scale");

        // Flush the last two samples.
        step(0, 0, 1'b0, "flush");
        step(0, 0, 1'b0, "flush");
        step(0, 0, 1'b0, "flush");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule